// File: doc/BRIEF.md
# Debug Monitor Entry Decision Unit

This block settles, once per power-on, whether the device boots into its debug monitor and in which flavour. It watches the reset pin for its first low-to-high transition. On that transition it samples a high-voltage test flag on the interrupt pin, a high-voltage flag on the reset pin, a divisor-select pin and a flag that reports an unprogrammed reset vector. From those samples it selects one of three outcomes: normal monitor entry, forced monitor entry, or ordinary user start.

The registered outputs tell the rest of the chip four things. They report whether monitor mode is active and whether it was forced. They choose between a divide-by-two bus clock, which bypasses one divider stage, and the usual divide-by-four. They say whether the watchdog must stay off, and which page the reset, software-interrupt and break vectors are fetched from. When monitor mode starts with a blank reset vector, the unit also asks for a short extra reset. The choice holds until the next power-on reset. The one exception is the watchdog disable, which is released after a normal entry made through the interrupt pin once the test voltage leaves that pin.

Top module: `monEntryTop`

## Requirements
- R1: While and right after power-on reset (rstN low), the outputs read monMode=0, forcedMode=0, busDiv2=0, wdDisable=0, vecPage=0xFF and extraRst=0.
- R2: The decision is taken only at the first clock edge where rstPin is sampled high after having been sampled low since power-on. The outputs change right after that edge. Later changes on irqHv, rstHv, divSel, vecBlank or rstPin leave monMode, forcedMode, busDiv2 and vecPage unchanged until the next power-on.
- R3: If irqHv or rstHv is high at the deciding edge, normal monitor mode is entered: monMode=1 and forcedMode=0.
- R4: busDiv2=1 (bus clock is the input divided by two) only for a normal entry with irqHv high and divSel low at the deciding edge. In every other case busDiv2=0 (divide by four).
- R5: If irqHv and rstHv are both low and vecBlank is high at the deciding edge, forced monitor mode is entered: monMode=1 and forcedMode=1, and busDiv2=0 whatever divSel is.
- R6: In forced monitor mode, wdDisable=1 and stays 1 until the next power-on.
- R7: Any normal entry sets wdDisable=1. If rstHv was high at the deciding edge, it stays 1. If rstHv was low, wdDisable drops to 0 right after the first later edge that samples irqHv low, and it does not return to 1.
- R8: vecPage is 0xFE while monMode=1 and 0xFF otherwise.
- R9: A monitor entry, normal or forced, with vecBlank high at the deciding edge drives extraRst high for EXTRA_CYCLES clocks (1 by default), starting right after the deciding edge. extraRst is 0 at all other times.
- R10: With irqHv, rstHv and vecBlank all low at the deciding edge, the unit stays in user mode: monMode=0, forcedMode=0, busDiv2=0, wdDisable=0, vecPage=0xFF, extraRst=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| rstPin | input | 1 | Reset pin level, sampled for its rising edge |
| irqHv | input | 1 | Test high voltage present on the interrupt pin |
| rstHv | input | 1 | Test high voltage present on the reset pin |
| divSel | input | 1 | Divisor select pin (low requests the divide-by-two bypass) |
| vecBlank | input | 1 | Reset vector is unprogrammed |
| monMode | output | 1 | Monitor mode active |
| forcedMode | output | 1 | Monitor mode entered through the forced path |
| busDiv2 | output | 1 | 1: bus clock = input/2, 0: input/4 |
| wdDisable | output | 1 | Watchdog must be held off |
| vecPage | output | PAGE_W | Page used for reset, SWI and break vectors |
| extraRst | output | 1 | Request for an extra reset period |

## Verification
Two functions can act in the clock right after the deciding edge: the extra-reset pulse and the watchdog release. The bench triggers both at once. It makes a normal entry through the interrupt pin with a blank vector, then removes irqHv in the very first cycle after the decision. The test passes only if, after the next edge, extraRst has ended after exactly one cycle and wdDisable has dropped. A second overlap arises when a new reset-pin rising edge arrives while the test inputs are changing. That run must show that none of the latched outputs moves.

// File: rtl/monEntryPkg.sv
package monEntryPkg;

  typedef enum logic [1:0] {
    ENTRY_USER   = 2'd0,
    ENTRY_NORMAL = 2'd1,
    ENTRY_FORCED = 2'd2
  } entryKind_e;

  typedef enum logic {
    CTL_WAIT = 1'b0,
    CTL_DONE = 1'b1
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       latch;        // deciding edge, capture outcome
    entryKind_e kind;         // chosen outcome
    logic       fastClk;      // divide-by-two bypass granted
    logic       wdFollowIrq;  // watchdog hold tied to interrupt-pin voltage
    logic       wantExtra;    // blank vector seen at decision
    logic       irqLow;       // interrupt-pin voltage absent this cycle (after decision)
  } ctlStrobe_t;

endpackage

// File: rtl/monEntryCtl.sv
module monEntryCtl
  import monEntryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPin,
  input  logic       irqHv,
  input  logic       rstHv,
  input  logic       divSel,
  input  logic       vecBlank,
  output ctlStrobe_t strobe
);

  ctlState_e state;
  logic      rstPinQ;
  logic      pinRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPinQ <= 1'b1;
      state   <= CTL_WAIT;
    end else begin
      rstPinQ <= rstPin;
      if (strobe.latch) state <= CTL_DONE;
    end
  end

  assign pinRise = rstPin & ~rstPinQ;

  always_comb begin
    strobe             = '0;
    strobe.kind        = ENTRY_USER;
    if (state == CTL_WAIT && pinRise) begin
      strobe.latch = 1'b1;
      if (irqHv || rstHv) begin
        strobe.kind        = ENTRY_NORMAL;
        strobe.fastClk     = irqHv & ~divSel;
        strobe.wdFollowIrq = ~rstHv;
        strobe.wantExtra   = vecBlank;
      end else if (vecBlank) begin
        strobe.kind      = ENTRY_FORCED;
        strobe.wantExtra = 1'b1;
      end
    end
    strobe.irqLow = (state == CTL_DONE) && !irqHv;
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    (state == CTL_DONE) |-> !strobe.latch); // R2

  AST_DECIDE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |-> (rstPin && !rstPinQ)); // R2

endmodule

// File: rtl/monEntryDp.sv
module monEntryDp
  import monEntryPkg::*;
#(
  parameter int PAGE_W       = 8,
  parameter int MON_PAGE     = 'hFE,
  parameter int USER_PAGE    = 'hFF,
  parameter int EXTRA_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  output logic              monMode,
  output logic              forcedMode,
  output logic              busDiv2,
  output logic              wdDisable,
  output logic [PAGE_W-1:0] vecPage,
  output logic              extraRst
);

  localparam logic [PAGE_W-1:0] MON_PG  = PAGE_W'(MON_PAGE);
  localparam logic [PAGE_W-1:0] USER_PG = PAGE_W'(USER_PAGE);

  logic monQ, forcedQ, div2Q, wdDisQ, wdFollowQ;
  logic [PAGE_W-1:0] pageQ;
  logic isMon;

  assign isMon = (strobe.kind != ENTRY_USER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monQ      <= 1'b0;
      forcedQ   <= 1'b0;
      div2Q     <= 1'b0;
      wdDisQ    <= 1'b0;
      wdFollowQ <= 1'b0;
      pageQ     <= USER_PG;
    end else if (strobe.latch) begin
      monQ      <= isMon;
      forcedQ   <= (strobe.kind == ENTRY_FORCED);
      div2Q     <= (strobe.kind == ENTRY_NORMAL) & strobe.fastClk;
      wdDisQ    <= isMon;
      wdFollowQ <= (strobe.kind == ENTRY_NORMAL) & strobe.wdFollowIrq;
      pageQ     <= isMon ? MON_PG : USER_PG;
    end else if (strobe.irqLow && wdFollowQ) begin
      wdDisQ    <= 1'b0;
      wdFollowQ <= 1'b0;
    end
  end

  generate
    if (EXTRA_CYCLES > 0) begin : g_extra
      localparam int CNT_W = $clog2(EXTRA_CYCLES + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXTRA_CYCLES);
      logic [CNT_W-1:0] extraCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          extraCnt <= '0;
        else if (strobe.latch)
          extraCnt <= (isMon && strobe.wantExtra) ? CNT_LOAD : '0;
        else if (extraCnt != '0)
          extraCnt <= extraCnt - 1'b1;
      end
      assign extraRst = (extraCnt != '0);
    end else begin : g_noExtra
      assign extraRst = 1'b0;
    end
  endgenerate

  assign monMode    = monQ;
  assign forcedMode = forcedQ;
  assign busDiv2    = div2Q;
  assign wdDisable  = wdDisQ;
  assign vecPage    = pageQ;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> ($stable(monQ) && $stable(pageQ) && $stable(div2Q))); // R2
  AST_DIV_NORMAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    div2Q |-> (monQ && !forcedQ)); // R4
  AST_FORCED_IS_MON: assert property (@(posedge clk) disable iff (!rstN)
    forcedQ |-> monQ); // R5
  AST_FORCED_WD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    forcedQ |-> wdDisQ); // R6
  AST_WD_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (!wdDisQ && !strobe.latch) |=> !wdDisQ); // R7
  AST_PAGE_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (pageQ == MON_PG) == monQ); // R8
  AST_EXTRA_IN_MON: assert property (@(posedge clk) disable iff (!rstN)
    extraRst |-> monQ); // R9

endmodule

// File: rtl/monEntryTop.sv
module monEntryTop
  import monEntryPkg::*;
#(
  parameter int PAGE_W       = 8,
  parameter int MON_PAGE     = 'hFE,
  parameter int USER_PAGE    = 'hFF,
  parameter int EXTRA_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstPin,
  input  logic              irqHv,
  input  logic              rstHv,
  input  logic              divSel,
  input  logic              vecBlank,
  output logic              monMode,
  output logic              forcedMode,
  output logic              busDiv2,
  output logic              wdDisable,
  output logic [PAGE_W-1:0] vecPage,
  output logic              extraRst
);

  ctlStrobe_t strobe;

  monEntryCtl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .rstPin   (rstPin),
    .irqHv    (irqHv),
    .rstHv    (rstHv),
    .divSel   (divSel),
    .vecBlank (vecBlank),
    .strobe   (strobe)
  );

  monEntryDp #(
    .PAGE_W       (PAGE_W),
    .MON_PAGE     (MON_PAGE),
    .USER_PAGE    (USER_PAGE),
    .EXTRA_CYCLES (EXTRA_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .monMode    (monMode),
    .forcedMode (forcedMode),
    .busDiv2    (busDiv2),
    .wdDisable  (wdDisable),
    .vecPage    (vecPage),
    .extraRst   (extraRst)
  );

endmodule

// File: tb/sim_monEntryTop.sv
`timescale 1ns/1ps
module sim_monEntryTop;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstPin = 1'b0, irqHv = 1'b0, rstHv = 1'b0, divSel = 1'b0, vecBlank = 1'b0;
  logic monMode, forcedMode, busDiv2, wdDisable, extraRst;
  logic [7:0] vecPage;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  monEntryTop u0 (
    .clk(clk), .rstN(rstN), .rstPin(rstPin), .irqHv(irqHv), .rstHv(rstHv),
    .divSel(divSel), .vecBlank(vecBlank), .monMode(monMode),
    .forcedMode(forcedMode), .busDiv2(busDiv2), .wdDisable(wdDisable),
    .vecPage(vecPage), .extraRst(extraRst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkAll(input string req, input int m, input int f, input int d,
                        input int w, input int p, input int x);
    chk(req, "monMode", monMode, m);
    chk(req, "forcedMode", forcedMode, f);
    chk(req, "busDiv2", busDiv2, d);
    chk(req, "wdDisable", wdDisable, w);
    chk(req, "vecPage", vecPage, p);
    chk(req, "extraRst", extraRst, x);
  endtask

  task automatic powerOn();
    @(negedge clk);
    rstN = 1'b0; rstPin = 1'b0;
    irqHv = 1'b0; rstHv = 1'b0; divSel = 1'b0; vecBlank = 1'b0;
    step();
    rstN = 1'b1;
    step();
  endtask

  // raise the reset pin; sample just after the deciding edge
  task automatic decide();
    rstPin = 1'b1;
    step();
  endtask

  task automatic testReset();
    @(negedge clk);
    chkAll("R1", 0, 0, 0, 0, 'hFF, 0);
    powerOn();
    irqHv = 1'b1;
    step();
    chkAll("R2 before edge", 0, 0, 0, 0, 'hFF, 0);
  endtask

  task automatic testNormalIrqFast();
    powerOn();
    irqHv = 1'b1; divSel = 1'b0;
    decide();
    chkAll("R3 R4 R8", 1, 0, 1, 1, 'hFE, 0);
    divSel = 1'b1; rstHv = 1'b1; vecBlank = 1'b1; rstPin = 1'b0;
    step();
    rstPin = 1'b1;
    step(); step();
    chkAll("R2 hold", 1, 0, 1, 1, 'hFE, 0);
    rstHv = 1'b0;
    irqHv = 1'b0;
    step();
    chk("R7", "wd release", wdDisable, 0);
    irqHv = 1'b1;
    step(); step();
    chk("R7", "wd no rearm", wdDisable, 0);
    chk("R2", "mode kept", monMode, 1);
  endtask

  task automatic testNormalIrqSlow();
    powerOn();
    irqHv = 1'b1; divSel = 1'b1;
    decide();
    chkAll("R4 div4", 1, 0, 0, 1, 'hFE, 0);
  endtask

  task automatic testNormalRstHv();
    powerOn();
    rstHv = 1'b1; divSel = 1'b0;
    decide();
    chkAll("R3 R4 via pin", 1, 0, 0, 1, 'hFE, 0);
    rstHv = 1'b0;
    for (int i = 0; i < 6; i++) step();
    chk("R7", "wd held via reset pin", wdDisable, 1);
  endtask

  task automatic testForced();
    powerOn();
    vecBlank = 1'b1; divSel = 1'b0;
    decide();
    chkAll("R5 R6 R8 R9", 1, 1, 0, 1, 'hFE, 1);
    irqHv = 1'b1;
    step();
    chk("R9", "pulse length", extraRst, 0);
    irqHv = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R6", "wd held forced", wdDisable, 1);
    chk("R5", "forced kept", forcedMode, 1);
  endtask

  task automatic testUser();
    powerOn();
    decide();
    chkAll("R10", 0, 0, 0, 0, 'hFF, 0);
    irqHv = 1'b1; vecBlank = 1'b1; rstPin = 1'b0;
    step();
    rstPin = 1'b1;
    step();
    chkAll("R2 no late entry", 0, 0, 0, 0, 'hFF, 0);
  endtask

  task automatic testOverlap();
    powerOn();
    irqHv = 1'b1; divSel = 1'b0; vecBlank = 1'b1;
    decide();
    chkAll("R9 R7 overlap", 1, 0, 1, 1, 'hFE, 1);
    irqHv = 1'b0;
    step();
    chk("R9", "pulse ended", extraRst, 0);
    chk("R7", "wd released same cycle", wdDisable, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testNormalIrqFast();
        testNormalIrqSlow();
        testNormalRstHv();
        testForced();
        testUser();
        testOverlap();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule